// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns the two phase-shifted square waves of an incremental rotary or linear encoder into a signed position count. Both raw channels are brought into the system clock domain by a flop chain. Each then passes a stability filter that ignores any level lasting fewer than four clocks. The cleaned pair drives a four-phase state machine. Each legal single-channel move gives a one-cycle direction pulse and steps a wrapping position counter. A move in which both channels change together cannot be given a direction. It is not counted, and it raises a sticky error flag.

The system clock must run at least ten times faster than the fastest encoder edge rate, so that each level outlives the filter window. A synchronous clear input zeroes the count. After reset the decoder spends a short settling window taking its phase from the filtered inputs, so that no count is produced at start-up.

Top module: `quad_decoder`

## Requirements
- R1: A level change on a raw channel that holds steadily produces its direction pulse, and the count update, on the 7th rising edge that samples the new level. This is 2 synchronizer stages, then 4 filter clocks, then 1 register stage.
- R2: A filtered channel follows its raw input only after the synchronized input has differed from the filter output on 4 consecutive clock edges.
- R3: A raw level that lasts 3 clocks or fewer, then returns, produces no pulse and leaves the count unchanged.
- R4: With the phase code {A,B} taking the values 00, 10, 11 and 01 in turn, each forward move (00→10→11→01→00) gives a one-cycle up_o pulse and adds 1 to pos_o.
- R5: Each backward move (00→01→11→10→00) gives a one-cycle dn_o pulse and subtracts 1 from pos_o.
- R6: A direction pulse lasts exactly one clock, and pos_o changes in the same cycle the pulse is high.
- R7: A move in which both filtered channels change on the same edge leaves pos_o unchanged and gives no pulse. It sets err_o, which stays set until reset, and decoding goes on from the new phase.
- R8: pos_o is 16-bit two's complement. It wraps from 0x0000 to 0xFFFF when counting down and from 0xFFFF to 0x0000 when counting up.
- R9: clear_i high at a clock edge sets pos_o to 0 at that edge. If a step falls in the same cycle, the clear wins, and the direction pulse is still given.
- R10: During reset and for the first 8 clocks after release, pos_o is 0 and up_o, dn_o and err_o are low. The phase is taken from the filtered inputs, so a non-zero start phase gives no count.
- R11: up_o and dn_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Raw encoder channel A, asynchronous |
| enc_b_i | input | 1 | Raw encoder channel B, asynchronous |
| clear_i | input | 1 | Synchronous position clear |
| pos_o | output | 16 | Signed position count |
| up_o | output | 1 | One-cycle forward step pulse |
| dn_o | output | 1 | One-cycle backward step pulse |
| err_o | output | 1 | Sticky double-step error flag |

## Verification
A counter clear and a counted step can land on the same clock edge. The bench provokes this by holding clear_i high across the whole seven-clock latency of a forward move, so the step is sure to fall inside the clear. The result is judged correct only if pos_o reads zero while up_o is high in that same cycle. The reference model also counts how many such coincidences it saw, and a run that never reached one is marked as a failure.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // Phase code is {A,B}; forward order 00 -> 10 -> 11 -> 01
  typedef enum logic [1:0] {
    PH0 = 2'b00,
    PH1 = 2'b10,
    PH2 = 2'b11,
    PH3 = 2'b01
  } phase_t;

  function automatic phase_t phase_fwd(phase_t p);
    case (p)
      PH0:     return PH1;
      PH1:     return PH2;
      PH2:     return PH3;
      default: return PH0;
    endcase
  endfunction

  function automatic phase_t phase_bwd(phase_t p);
    case (p)
      PH0:     return PH3;
      PH3:     return PH2;
      PH2:     return PH1;
      default: return PH0;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i != lvl_q) begin
      if (run_q == CW'(LEN-1)) begin
        lvl_q <= d_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/qdec_fsm.sv
module qdec_fsm
  import qdec_pkg::*;
#(
  parameter int SETTLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic inc_o,
  output logic dec_o,
  output logic up_o,
  output logic dn_o,
  output logic err_o
);
  localparam int WW = $clog2(SETTLE + 1);

  phase_t        st_q, cur;
  logic          ready_q;
  logic [WW-1:0] wait_q;
  logic          up_q, dn_q, err_q, dbl;

  assign cur   = phase_t'({a_i, b_i});
  assign inc_o = ready_q && (cur == phase_fwd(st_q));
  assign dec_o = ready_q && (cur == phase_bwd(st_q));
  // neither neighbour nor same phase: both channels moved
  assign dbl   = ready_q && (cur != st_q) && !inc_o && !dec_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH0;
      ready_q <= 1'b0;
      wait_q  <= '0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q <= cur;
      if (!ready_q) begin
        wait_q <= wait_q + 1'b1;
        if (wait_q == WW'(SETTLE-1)) ready_q <= 1'b1;
      end
      up_q <= inc_o;
      dn_q <= dec_o;
      if (dbl) err_q <= 1'b1;
    end
  end

  assign up_o  = up_q;
  assign dn_o  = dn_q;
  assign err_o = err_q;
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (clr_i) pos_q <= '0;
    else if (inc_i) pos_q <= pos_q + 1'b1;
    else if (dec_i) pos_q <= pos_q - 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int POS_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             clear_i,
  output logic [POS_W-1:0] pos_o,
  output logic             up_o,
  output logic             dn_o,
  output logic             err_o
);
  localparam int SETTLE = SYNC_STAGES + FILT_LEN + 2;

  logic [1:0] raw, synced, filt;
  logic       inc, dec;

  assign raw = {enc_a_i, enc_b_i};

  for (genvar g = 0; g < 2; g++) begin : g_chan
    qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (synced[g])
    );
    qdec_filter #(.LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (synced[g]),
      .q_o   (filt[g])
    );
  end

  qdec_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (filt[1]),
    .b_i   (filt[0]),
    .inc_o (inc),
    .dec_o (dec),
    .up_o  (up_o),
    .dn_o  (dn_o),
    .err_o (err_o)
  );

  qdec_counter #(.W(POS_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clear_i),
    .inc_i (inc),
    .dec_i (dec),
    .pos_o (pos_o)
  );
endmodule

// File: rtl/quad_decoder_checker.sv
module quad_decoder_checker #(
  parameter int POS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic [POS_W-1:0] pos_o,
  input logic             up_o,
  input logic             dn_o,
  input logic             err_o
);
  p_excl_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  p_up_adds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && !$past(clear_i)) |-> (pos_o == $past(pos_o) + 1'b1));

  p_dn_subs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_o && !$past(clear_i)) |-> (pos_o == $past(pos_o) - 1'b1));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !dn_o && !$past(clear_i)) |-> $stable(pos_o));

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (pos_o == '0));
endmodule

bind quad_decoder quad_decoder_checker #(.POS_W(POS_W)) u_chk (.*);

// File: tb/quad_decoder_test.sv
module quad_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni, enc_a, enc_b, clr;
  logic [15:0] pos;
  logic        up, dn, err;

  always #2 clk = ~clk;

  quad_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .clear_i(clr), .pos_o(pos), .up_o(up), .dn_o(dn), .err_o(err)
  );

  int vecs = 0, bad = 0, coincide = 0;

  // reference model state
  int qa[$], qb[$];
  int fa, fb, ca, cb, st, rdy, wcnt, m_pos, m_up, m_dn, m_err;

  function automatic int ph_idx(int code);
    case (code)
      0: return 0;   // 00
      2: return 1;   // 10
      3: return 2;   // 11
      default: return 3; // 01
    endcase
  endfunction

  function automatic void model_reset();
    qa = {0, 0}; qb = {0, 0};
    fa = 0; fb = 0; ca = 0; cb = 0; st = 0; rdy = 0; wcnt = 0;
    m_pos = 0; m_up = 0; m_dn = 0; m_err = 0;
  endfunction

  function automatic void filt_step(int din, ref int lvl, ref int run);
    if (din != lvl) begin
      if (run == 3) begin lvl = din; run = 0; end
      else run++;
    end else run = 0;
  endfunction

  function automatic void model_edge(int ra, int rb, int rc);
    int cur, nu, nd, sa, sb;
    cur = fa * 2 + fb;
    nu = 0; nd = 0;
    if (rdy == 0) begin
      if (wcnt == 7) rdy = 1;
      wcnt++;
    end else if (cur != st) begin
      if (ph_idx(cur) == (ph_idx(st) + 1) % 4) nu = 1;
      else if (ph_idx(cur) == (ph_idx(st) + 3) % 4) nd = 1;
      else m_err = 1;
    end
    st = cur;
    if (rc != 0) begin
      m_pos = 0;
      if (nu != 0 || nd != 0) coincide++;
    end else if (nu != 0) m_pos = (m_pos + 1) & 16'hFFFF;
    else if (nd != 0) m_pos = (m_pos - 1) & 16'hFFFF;
    m_up = nu; m_dn = nd;
    sa = qa.pop_front(); sb = qb.pop_front();
    filt_step(sa, fa, ca);
    filt_step(sb, fb, cb);
    qa.push_back(ra); qb.push_back(rb);
  endfunction

  task automatic check(string tag);
    vecs++;
    if (pos !== 16'(m_pos) || up !== 1'(m_up) || dn !== 1'(m_dn) || err !== 1'(m_err)) begin
      bad++;
      $display("FAIL %s: pos=%h up=%b dn=%b err=%b expected pos=%h up=%0d dn=%0d err=%0d",
               tag, pos, up, dn, err, 16'(m_pos), m_up, m_dn, m_err);
    end
    if (up === 1'b1 && dn === 1'b1) begin
      bad++;
      $display("FAIL R11: up=%b dn=%b expected not both high", up, dn);
    end
  endtask

  task automatic cyc(int a, int b, int c, int n, string tag);
    for (int i = 0; i < n; i++) begin
      enc_a = 1'(a); enc_b = 1'(b); clr = 1'(c);
      @(posedge clk);
      model_edge(a, b, c);
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic expect_pos(int exp, string tag);
    vecs++;
    if (pos !== 16'(exp)) begin
      bad++;
      $display("FAIL %s: pos=%h expected %h", tag, pos, 16'(exp));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; enc_a = 1'b1; enc_b = 1'b1; clr = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R10 reset state");
    rst_ni = 1'b1;

    // R10: start phase 11, no spurious count while settling
    cyc(1, 1, 0, 14, "R10 settle");

    // R1: latency of the first forward move 11 -> 01
    for (int i = 1; i <= 8; i++) begin
      cyc(0, 1, 0, 1, "R1 latency");
      vecs++;
      if (up !== ((i == 7) ? 1'b1 : 1'b0)) begin
        bad++;
        $display("FAIL R1: edge %0d up=%b expected %b", i, up, (i == 7));
      end
    end
    cyc(0, 1, 0, 4, "R6 hold");

    // R4/R6: forward moves 01 -> 00 -> 10 -> 11
    cyc(0, 0, 0, 10, "R4 fwd");
    cyc(1, 0, 0, 10, "R4 fwd");
    cyc(1, 1, 0, 10, "R4 fwd");
    expect_pos(4, "R4 four forward moves");

    // R5: backward moves 11 -> 10 -> 00 -> 01 -> 11
    cyc(1, 0, 0, 10, "R5 bwd");
    cyc(0, 0, 0, 10, "R5 bwd");
    cyc(0, 1, 0, 10, "R5 bwd");
    cyc(1, 1, 0, 10, "R5 bwd");
    expect_pos(0, "R5 four backward moves");

    // R3: short glitches on A are rejected
    cyc(0, 1, 0, 3, "R3 glitch");
    cyc(1, 1, 0, 10, "R3 glitch");
    cyc(1, 0, 0, 2, "R3 glitch");
    cyc(1, 1, 0, 10, "R3 glitch");
    expect_pos(0, "R3 glitch ignored");

    // R2: exactly four clocks passes the filter (fwd then back)
    cyc(0, 1, 0, 4, "R2 four clocks");
    cyc(1, 1, 0, 14, "R2 four clocks");
    expect_pos(0, "R2 pass and return");

    // R8: underflow then overflow
    cyc(1, 0, 0, 10, "R8 underflow");
    expect_pos(16'hFFFF, "R8 underflow");
    cyc(1, 1, 0, 10, "R8 overflow");
    expect_pos(0, "R8 overflow");

    // R9: clear coinciding with a step
    cyc(0, 1, 0, 10, "R9 pre");
    expect_pos(1, "R9 pre");
    cyc(0, 0, 1, 10, "R9 clear+step");
    cyc(0, 0, 0, 2, "R9 after");
    expect_pos(0, "R9 clear wins");
    cyc(1, 0, 0, 10, "R9 step");
    cyc(1, 0, 1, 2, "R9 clear alone");
    expect_pos(0, "R9 clear alone");
    vecs++;
    if (coincide == 0) begin
      bad++;
      $display("FAIL R9: coincidences=%0d expected >0", coincide);
    end

    // R7: double step 10 -> 01, no count, sticky error
    cyc(0, 1, 0, 10, "R7 double step");
    expect_pos(0, "R7 no count");
    cyc(0, 0, 0, 10, "R7 continues");
    expect_pos(1, "R7 decoding continues");
    vecs++;
    if (err !== 1'b1) begin
      bad++;
      $display("FAIL R7: err=%b expected 1", err);
    end

    // R10: reset clears error and count
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    check("R10 second reset");
    rst_ni = 1'b1;
    cyc(0, 0, 0, 12, "R10 settle again");

    summary();
    $finish;
  end
endmodule